// File: doc/BRIEF.md
# Set/Clear GPIO Controller

This block is a twenty-line general-purpose I/O peripheral on a plain 64-bit register bus. Each line has its own configuration word that holds one output-enable flag. The value a line drives is held in an output latch. Software can change that latch only through two strobe registers: one sets bits and one clears bits. Each access changes exactly the lines whose data bits are 1, so no read-modify-write sequence is needed and two agents never race on the same word. A read-only word returns the pin levels after they have passed through a synchronizer.

The pad side is a tri-state triple for each line: an output-enable vector, an output-value vector and an input vector. The configuration words are split into two windows. Lines 0 to 15 sit in a low window and lines 16 to 19 sit in a high window at 0x100. Any access that hits no register returns zero and raises a one-cycle error pulse. Software may load the latch while a line is still an input. When the line is enabled later, the pad presents the loaded value at once.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every output enable is 0, every output latch bit is 0, `rsp_err` is 0 and `rsp_rdata` is 0.
- R2: A write to byte offset 0x88 sets each latch bit n (n < 20) whose write-data bit n is 1. Zero bits and data bits 20..63 change nothing. The new latch value appears on `pad_out` right after the accepting clock edge.
- R3: A write to byte offset 0x90 clears each latch bit n (n < 20) whose write-data bit n is 1. Zero bits and data bits 20..63 change nothing. The result appears on `pad_out` right after the accepting edge.
- R4: The configuration word of line n is at byte offset 8*n when n < 16 and at 0x100 + 8*(n-16) when n >= 16. Its bit 0 is the output enable. A write loads `pad_oe[n]` from data bit 0, leaves every other line alone, and takes effect right after the accepting edge.
- R5: A read of a configuration word returns the output enable in bit 0 and zero in bits 1..63. Writes to bits 1..63 have no effect.
- R6: A read of byte offset 0x80 returns `pad_in` in bits 0..19 and zero above. A pin change made before edge E is visible to a read accepted at edge E+2, but not to reads accepted at E or E+1.
- R7: A read of offset 0x88 or of offset 0x90 returns the current output latch in bits 0..19 and zero above.
- R8: A configuration write never changes the output latch. A value loaded while a line is an input is on `pad_out[n]` in the same cycle that `pad_oe[n]` rises.
- R9: An access is unmapped if its low three address bits are not zero or if its offset is not one of the words above. An unmapped access returns `rsp_rdata` of zero, raises `rsp_err` for exactly the one cycle after the accepting edge, and changes no pad output.
- R10: A write to offset 0x80 is accepted without error and changes no latch or enable.
- R11: Read data and the error flag are registered. Both are valid in the cycle after the edge that accepts the request. `rsp_rdata` holds its value until the next read or unmapped access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Registered read data |
| rsp_err | output | 1 | One-cycle pulse for an unmapped access |
| pad_in | input | 20 | Raw pin levels |
| pad_oe | output | 20 | Per-line driver enable |
| pad_out | output | 20 | Per-line driven value |

## Verification
Each result has a fixed number of edges before it is due:
- Writes to the set word, the clear word and the configuration words change `pad_out` and `pad_oe` one edge after the request is accepted.
- Read data and the error pulse also follow one edge after acceptance.
- A pin change reaches the read data only through two synchronizer edges plus the read register.

Every bus task presents its request on a falling edge, lets exactly one rising edge accept it, and samples the outputs on the following falling edge. The pin-latency test issues back-to-back reads on consecutive edges after a pin change. It expects the old value at the first and second edges and the new value at the third. To confirm that an error pulse lasts one cycle, the bench checks `rsp_err` again one idle cycle after the access.

// File: rtl/gpio_setclr_pkg.sv
// Package: shared constants and the access-kind type for the set/clear GPIO
// controller. Assumes byte addressing with 64-bit (8-byte) registers.
package gpio_setclr_pkg;

    // Default geometry of the controller.
    localparam int GPIO_LINES     = 20;
    localparam int GPIO_LOW_BANK  = 16;
    localparam int GPIO_HIGH_BASE = 'h100;
    localparam int GPIO_ADDR_W    = 12;
    localparam int GPIO_DATA_W    = 64;

    // Fixed word offsets whose meaning software depends on.
    localparam int OFS_PINS = 'h80;
    localparam int OFS_SET  = 'h88;
    localparam int OFS_CLR  = 'h90;

    // What an address selects.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_PINS,
        ACC_SET,
        ACC_CLR
    } acc_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Turns a byte offset into an access kind and, for configuration words, a
// line index. Purely combinational. Assumes the low window holds lines
// 0..LOW_BANK-1 at 8*n and the high window holds the rest at HIGH_BASE.
// Misaligned offsets decode as ACC_NONE.
module gpio_addr_decode
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_LINES = GPIO_LINES,
    parameter int LOW_BANK  = GPIO_LOW_BANK,
    parameter int HIGH_BASE = GPIO_HIGH_BASE,
    parameter int ADDR_W    = GPIO_ADDR_W,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [LINE_W-1:0] line_idx
);

    localparam logic [ADDR_W-1:0] LOW_END  = ADDR_W'(LOW_BANK * 8);
    localparam logic [ADDR_W-1:0] HIGH_LO  = ADDR_W'(HIGH_BASE);
    localparam logic [ADDR_W-1:0] HIGH_END = ADDR_W'(HIGH_BASE + 8 * (NUM_LINES - LOW_BANK));

    logic [ADDR_W-1:0] high_off;
    logic              aligned;

    assign high_off = addr - HIGH_LO;
    assign aligned  = (addr[2:0] == 3'b000);

    // Classify the offset and compute the configuration line it names.
    always_comb begin
        kind     = ACC_NONE;
        line_idx = '0;
        if (aligned) begin
            if (addr < LOW_END) begin
                kind     = ACC_CFG;
                line_idx = LINE_W'(addr[ADDR_W-1:3]);
            end else if (addr == ADDR_W'(OFS_PINS)) begin
                kind = ACC_PINS;
            end else if (addr == ADDR_W'(OFS_SET)) begin
                kind = ACC_SET;
            end else if (addr == ADDR_W'(OFS_CLR)) begin
                kind = ACC_CLR;
            end else if (addr >= HIGH_LO && addr < HIGH_END) begin
                kind     = ACC_CFG;
                line_idx = LINE_W'(LOW_BANK) + LINE_W'(high_off[ADDR_W-1:3]);
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchronizer for each input pin. Assumes the pins are
// independent; it does not keep a multi-bit value coherent.
module gpio_in_sync
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_LINES = GPIO_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pins_raw,
    output logic [NUM_LINES-1:0] pins_sync
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic stage1_q;
        logic stage2_q;

        // Two-stage capture of one pin into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= pins_raw[i];
                stage2_q <= stage1_q;
            end
        end

        assign pins_sync[i] = stage2_q;
    end

endmodule

// File: rtl/gpio_line_bank.sv
// Module: gpio_line_bank
// Holds the output latch and the output enable of every line. The latch
// changes only through set and clear strobes. The enable changes only
// through a configuration write to its own line. The two are separate
// registers, so raising an enable cannot disturb the value already latched.
// Assumes at most one strobe per cycle.
module gpio_line_bank
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_LINES = GPIO_LINES,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic                 cfg_we,
    input  logic [LINE_W-1:0]    cfg_idx,
    input  logic                 cfg_oe,
    input  logic [NUM_LINES-1:0] bit_mask,
    output logic [NUM_LINES-1:0] out_q,
    output logic [NUM_LINES-1:0] oe_q
);

    logic [NUM_LINES-1:0] set_mask;
    logic [NUM_LINES-1:0] clr_mask;

    assign set_mask = set_we ? bit_mask : '0;
    assign clr_mask = clr_we ? bit_mask : '0;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // Output latch of one line: set or clear on a strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)           out_q[i] <= 1'b0;
            else if (set_mask[i]) out_q[i] <= 1'b1;
            else if (clr_mask[i]) out_q[i] <= 1'b0;
        end

        // Output enable of one line: loaded by its own configuration write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  oe_q[i] <= 1'b0;
            else if (cfg_we && cfg_idx == LINE_W'(i))    oe_q[i] <= cfg_oe;
        end
    end

    // R2: every bit named by a set strobe is 1 afterwards.
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((out_q & $past(bit_mask)) == $past(bit_mask)));

    // R3: every bit named by a clear strobe is 0 afterwards.
    a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((out_q & $past(bit_mask)) == '0));

    // R4: enables move only on a configuration write.
    a_r4_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(oe_q));

    // R4: a configuration write touches at most one enable.
    a_r4_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ($countones(oe_q ^ $past(oe_q)) <= 1));

    // R8: a configuration write leaves the latch untouched.
    a_r8_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !set_we && !clr_we) |=> $stable(out_q));

endmodule

// File: rtl/gpio_setclr_ctrl.sv
// Module: gpio_setclr_ctrl (top)
// Twenty-line GPIO controller on a simple 64-bit register bus. It decodes
// each access, steers writes to the line bank, and registers the read data
// and the error pulse. Assumes one access per cycle with no back-pressure.
// Results are due one edge after acceptance.
module gpio_setclr_ctrl
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_LINES = GPIO_LINES,
    parameter int LOW_BANK  = GPIO_LOW_BANK,
    parameter int HIGH_BASE = GPIO_HIGH_BASE,
    parameter int ADDR_W    = GPIO_ADDR_W,
    parameter int DATA_W    = GPIO_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] pad_out
);

    localparam int LINE_W = $clog2(NUM_LINES);
    localparam int PAD_W  = DATA_W - NUM_LINES;

    acc_kind_e            kind;
    logic [LINE_W-1:0]    line_idx;
    logic [NUM_LINES-1:0] pins_sync;
    logic [NUM_LINES-1:0] latch_q;
    logic [NUM_LINES-1:0] oe_q;
    logic [DATA_W-1:0]    rd_mux;
    logic                 wr_go;
    logic                 unused_hi;

    assign wr_go     = req_valid && req_write;
    assign unused_hi = ^req_wdata[DATA_W-1:NUM_LINES];

    gpio_addr_decode #(
        .NUM_LINES (NUM_LINES),
        .LOW_BANK  (LOW_BANK),
        .HIGH_BASE (HIGH_BASE),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (req_addr),
        .kind     (kind),
        .line_idx (line_idx)
    );

    gpio_in_sync #(
        .NUM_LINES (NUM_LINES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_raw  (pad_in),
        .pins_sync (pins_sync)
    );

    gpio_line_bank #(
        .NUM_LINES (NUM_LINES)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (wr_go && kind == ACC_SET),
        .clr_we   (wr_go && kind == ACC_CLR),
        .cfg_we   (wr_go && kind == ACC_CFG),
        .cfg_idx  (line_idx),
        .cfg_oe   (req_wdata[0]),
        .bit_mask (req_wdata[NUM_LINES-1:0]),
        .out_q    (latch_q),
        .oe_q     (oe_q)
    );

    // Select the word a read returns.
    always_comb begin
        unique case (kind)
            ACC_CFG:           rd_mux = {{(DATA_W-1){1'b0}}, oe_q[line_idx]};
            ACC_PINS:          rd_mux = {{PAD_W{1'b0}}, pins_sync};
            ACC_SET, ACC_CLR:  rd_mux = {{PAD_W{1'b0}}, latch_q};
            default:           rd_mux = '0;
        endcase
    end

    // Register the read data and the unmapped-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_err <= req_valid && (kind == ACC_NONE);
            if (req_valid && (!req_write || kind == ACC_NONE)) begin
                rsp_rdata <= rd_mux;
            end
        end
    end

    assign pad_oe  = oe_q;
    assign pad_out = latch_q;

    // R1: reset leaves every line an undriven input with a low latch.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && !rsp_err));

    // R9: an error pulse always follows an accepted access.
    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(req_valid));

    // R9: an error pulse carries zero read data.
    a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R9: an unmapped access moves no pad output.
    a_r9_pads_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_NONE) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/gpio_setclr_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_setclr_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic [19:0] pad_in = '0;
    logic [19:0] pad_oe;
    logic [19:0] pad_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [19:0] exp_out = '0;
    logic [19:0] exp_oe  = '0;

    always #2.5 clk = ~clk;

    gpio_setclr_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic bus_write(input logic [11:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [63:0] d, output logic e);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; e = rsp_err;
    endtask

    function automatic logic [11:0] cfg_addr(input int n);
        return (n < 16) ? 12'(8 * n) : 12'('h100 + 8 * (n - 16));
    endfunction

    task automatic t_reset();
        check("R1 pad_oe", 64'(pad_oe), 64'h0);
        check("R1 pad_out", 64'(pad_out), 64'h0);
        check("R1 rsp_err", 64'(rsp_err), 64'h0);
        check("R1 rsp_rdata", rsp_rdata, 64'h0);
    endtask

    task automatic t_set_clear();
        logic [63:0] d; logic e;
        bus_write(12'h088, 64'hFFFF_FFFF_FFF0_0005);
        exp_out = 20'h00005;
        check("R2 set with high bits", 64'(pad_out), 64'(exp_out));
        bus_write(12'h088, 64'h0000_0000_0008_0010);
        exp_out = 20'h80015;
        check("R2 set keeps others", 64'(pad_out), 64'(exp_out));
        bus_write(12'h090, 64'h0000_0000_0000_0004);
        exp_out = 20'h80011;
        check("R3 clear one bit", 64'(pad_out), 64'(exp_out));
        bus_write(12'h090, 64'hFFFF_FFFF_FFF0_0000);
        check("R3 clear high bits ignored", 64'(pad_out), 64'(exp_out));
        bus_read(12'h090, d, e);
        check("R7 read clear word", d, 64'(exp_out));
        bus_read(12'h088, d, e);
        check("R7 read set word", d, 64'(exp_out));
        check("R11 no error on read", 64'(e), 64'h0);
    endtask

    task automatic t_cfg_map();
        logic [63:0] d; logic e;
        int lines[5] = '{0, 7, 15, 16, 19};
        foreach (lines[k]) begin
            bus_write(cfg_addr(lines[k]), 64'h1);
            exp_oe[lines[k]] = 1'b1;
            check($sformatf("R4 enable line %0d", lines[k]), 64'(pad_oe), 64'(exp_oe));
            bus_read(cfg_addr(lines[k]), d, e);
            check($sformatf("R5 readback line %0d", lines[k]), d, 64'h1);
        end
        bus_write(cfg_addr(16), 64'hFFFF_FFFF_FFFF_FFFE);
        exp_oe[16] = 1'b0;
        check("R4 disable line 16", 64'(pad_oe), 64'(exp_oe));
        bus_read(cfg_addr(16), d, e);
        check("R5 upper bits dropped (0)", d, 64'h0);
        bus_write(cfg_addr(7), 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(cfg_addr(7), d, e);
        check("R5 upper bits dropped (1)", d, 64'h1);
        check("R8 latch unchanged by config", 64'(pad_out), 64'(exp_out));
    endtask

    task automatic t_preload();
        bus_write(12'h090, 64'hF_FFFF);
        exp_out = '0;
        bus_write(12'h088, 64'h8);
        exp_out = 20'h8;
        check("R8 preload while input oe", 64'(pad_oe[3]), 64'h0);
        check("R8 preload while input out", 64'(pad_out), 64'(exp_out));
        bus_write(cfg_addr(3), 64'h1);
        exp_oe[3] = 1'b1;
        check("R8 enable rises oe", 64'(pad_oe), 64'(exp_oe));
        check("R8 enable shows latched value", 64'(pad_out), 64'(exp_out));
    endtask

    task automatic t_pins();
        logic [63:0] d; logic e;
        pad_in = 20'hA5A5A;
        bus_read(12'h080, d, e);
        check("R6 first edge old value", d, 64'h0);
        bus_read(12'h080, d, e);
        check("R6 second edge old value", d, 64'h0);
        bus_read(12'h080, d, e);
        check("R6 third edge new value", d, 64'hA5A5A);
        pad_in = 20'h5A5A5;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        bus_read(12'h080, d, e);
        check("R6 second pattern", d, 64'h5A5A5);
    endtask

    task automatic t_unmapped();
        logic [63:0] d; logic e;
        bus_read(12'h098, d, e);
        check("R9 read 0x98 err", 64'(e), 64'h1);
        check("R9 read 0x98 data", d, 64'h0);
        @(posedge clk); @(negedge clk);
        check("R9 pulse one cycle", 64'(rsp_err), 64'h0);
        bus_read(12'h00C, d, e);
        check("R9 misaligned err", 64'(e), 64'h1);
        bus_write(12'h120, 64'hF_FFFF);
        check("R9 write past high window err", 64'(rsp_err), 64'h1);
        check("R9 oe kept", 64'(pad_oe), 64'(exp_oe));
        check("R9 out kept", 64'(pad_out), 64'(exp_out));
        bus_write(12'h0F8, 64'hF_FFFF);
        check("R9 write gap err", 64'(rsp_err), 64'h1);
        check("R9 gap out kept", 64'(pad_out), 64'(exp_out));
    endtask

    task automatic t_pin_write();
        logic [63:0] d; logic e;
        bus_write(12'h080, 64'hF_FFFF);
        check("R10 no error", 64'(rsp_err), 64'h0);
        check("R10 out kept", 64'(pad_out), 64'(exp_out));
        check("R10 oe kept", 64'(pad_oe), 64'(exp_oe));
        bus_read(12'h080, d, e);
        check("R10 pins still readable", d, 64'h5A5A5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_cfg_map();
        t_preload();
        t_pins();
        t_unmapped();
        t_pin_write();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule